// File: doc/BRIEF.md
# Multi-Channel Match-Compare Timer

This peripheral holds several independent up-counters, three by default, each 32 bits wide. Every counter drives a bank of match comparators, three per counter by default. A comparator raises a sticky status bit when the live count equals its stored value. Each timer folds its enabled status bits into one interrupt line.

Software reaches the block through a single-cycle register port. A write is taken on the rising clock edge while `wr_en` is high. Reads are combinational from `addr`. Through this port software starts and stops each counter and picks, per timer, whether the counter wraps freely or restarts after comparator 0 matches. Software also requests snapshots of a running count, which land in a capture register a fixed number of cycles after the request. A clock-select field and a mode bit per timer are stored and read back, but they steer nothing inside the block.

Register words (8-bit word address):
- Global words:
  - 0x00: clock select, 2 bits per timer.
  - 0x01: run control, 1 bit per timer.
  - 0x02: mode, 1 bit per timer.
- Per-timer block for timer t, at base 0x10·(t+1):
  - +0 to +2: match values for comparators 0 to 2.
  - +3: status.
  - +4: interrupt enable.
  - +5: reload control.
  - +6: capture.

Top module: `mc_match_timer`

## Requirements
- R1: After reset, every register reads zero and every `irq` bit is low.
- R2: Bit t of the run word (0x01) runs timer t. While the bit is set, the counter increases by one every clock. Writing 0x2 runs only timer 1 and leaves timer 0 stopped at zero.
- R3: While its run bit is clear, a counter is held at zero, so setting the bit again starts counting from zero.
- R4: Status bit k of a timer (word base+3) becomes 1 in the cycle after the running count equals match k (word base+k). With match value N-1 written before the run-bit write edge, the bit reads 1 exactly N clocks after that edge and 0 one clock earlier.
- R5: Writing the status word clears each bit written as 1 and leaves bits written as 0 unchanged. A match in the same cycle wins over the clear.
- R6: `irq[t]` is high exactly when some status bit of timer t is set and its bit in the enable word (base+4) is set. An enable word of zero holds `irq[t]` low.
- R7: A zero written to reload control (base+5) selects free-running counting, which wraps modulo 2^32. Any nonzero value selects periodic counting, in which the count returns to zero on the clock after comparator 0 matches. The word then reads back as 1.
- R8: A write of any data to the capture word (base+6) snapshots the count present in that write cycle. The snapshot becomes readable 4 clocks after the write edge. Until then the word returns the previous snapshot.
- R9: The clock-select word (0x00, 2 bits per timer, timer t in bits 2t+1:2t) and the mode word (0x02, bit t) read back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| addr | input | 8 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | One combined match interrupt per timer |

## Verification
Several behaviours hold on every clock and are checked there:
- a stopped counter sits at zero;
- a running counter steps by one, or returns to zero after a periodic comparator-0 match;
- every comparator hit leaves its status bit set;
- a capture snapshot moves only at the end of its delay window;
- an interrupt never rises while its enable word is zero.

Other behaviours only the bench's scenarios can show. These are the exact clock on which a match becomes visible for a given match value, the value a snapshot holds after a wrap in periodic mode, the per-bit effect of status clears, and the fact that a run word of 0x2 leaves timer 0 idle while timer 1 counts.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
  localparam int ADDR_W = 8;

  // global words
  localparam logic [ADDR_W-1:0] A_CLKSEL = 8'h00;
  localparam logic [ADDR_W-1:0] A_RUN    = 8'h01;
  localparam logic [ADDR_W-1:0] A_MODE   = 8'h02;

  // offsets inside a per-timer block (block index in addr[7:4])
  localparam logic [3:0] OFS_STAT   = 4'd3;
  localparam logic [3:0] OFS_IER    = 4'd4;
  localparam logic [3:0] OFS_RELOAD = 4'd5;
  localparam logic [3:0] OFS_CAP    = 4'd6;
endpackage

// File: rtl/mct_rst_sync.sv
`timescale 1ns/1ps
module mct_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mct_capture.sv
`timescale 1ns/1ps
module mct_capture #(
  parameter int CNT_W   = 32,
  parameter int CAP_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] cap_q
);
  localparam int DLY_W = (CAP_DLY < 2) ? 1 : $clog2(CAP_DLY);

  logic [CNT_W-1:0] pend_q, pend_d, cap_d;
  logic [DLY_W-1:0] left_q, left_d;
  logic             busy_q, busy_d;

  always_comb begin
    pend_d = pend_q;
    left_d = left_q;
    busy_d = busy_q;
    cap_d  = cap_q;
    if (trig) begin
      pend_d = live;
      left_d = DLY_W'(CAP_DLY - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (left_q == '0) begin
        cap_d  = pend_q;
        busy_d = 1'b0;
      end else begin
        left_d = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      pend_q <= pend_d;
      left_q <= left_d;
      busy_q <= busy_d;
      cap_q  <= cap_d;
    end
  end

  // R8
  cap_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy_q);
  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !trig) |=> $stable(cap_q));
  // R8
  cap_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !trig && left_q == '0) |=> (cap_q == $past(pend_q)));
endmodule

// File: rtl/mct_channel.sv
`timescale 1ns/1ps
module mct_channel #(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  parameter int CAP_DLY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_CMP-1:0] wr_match,
  input  logic               wr_stat,
  input  logic               wr_ier,
  input  logic               wr_reload,
  input  logic               wr_cap,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   match_q [NUM_CMP],
  output logic [NUM_CMP-1:0] stat_q,
  output logic [NUM_CMP-1:0] ier_q,
  output logic               periodic_q,
  output logic [CNT_W-1:0]   cap_q,
  output logic               irq
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [NUM_CMP-1:0] hit, stat_d, clr_mask;

  // comparators and their match registers
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           match_q[k] <= '0;
      else if (wr_match[k]) match_q[k] <= wdata;
    end
    assign hit[k] = run && (cnt_q == match_q[k]);

    // R4
    stat_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> stat_q[k]);
  end

  // counter next state
  always_comb begin
    if (!run)                       cnt_d = '0;
    else if (periodic_q && hit[0])  cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  // status: match sets, write-1 clears, set wins
  always_comb begin
    clr_mask = wr_stat ? wdata[NUM_CMP-1:0] : '0;
    stat_d   = (stat_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      stat_q     <= '0;
      ier_q      <= '0;
      periodic_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      if (wr_ier)    ier_q      <= wdata[NUM_CMP-1:0];
      if (wr_reload) periodic_q <= |wdata;
    end
  end

  assign irq = |(stat_q & ier_q);

  mct_capture #(.CNT_W(CNT_W), .CAP_DLY(CAP_DLY)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (wr_cap),
    .live  (cnt_q),
    .cap_q (cap_q)
  );

  // R3
  stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(periodic_q && hit[0])) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R7
  periodic_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && periodic_q && hit[0]) |=> (cnt_q == '0));
endmodule

// File: rtl/mc_match_timer.sv
`timescale 1ns/1ps
module mc_match_timer #(
  parameter int NUM_TMR = 3,
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  parameter int CS_W    = 2,
  parameter int CAP_DLY = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              addr,
  input  logic [CNT_W-1:0]        wdata,
  output logic [CNT_W-1:0]        rdata,
  output logic [NUM_TMR-1:0]      irq
);
  import mct_pkg::*;

  localparam int CS_TOT = NUM_TMR * CS_W;

  logic rst_n_s;

  logic [CS_TOT-1:0]  clksel_q, clksel_d;
  logic [NUM_TMR-1:0] run_q, run_d, mode_q, mode_d;
  logic               wr_clksel, wr_run, wr_mode;

  logic [CNT_W-1:0]   match_all [NUM_TMR][NUM_CMP];
  logic [NUM_CMP-1:0] stat_all  [NUM_TMR];
  logic [NUM_CMP-1:0] ier_all   [NUM_TMR];
  logic               per_all   [NUM_TMR];
  logic [CNT_W-1:0]   cap_all   [NUM_TMR];
  logic [CNT_W-1:0]   rdata_c;

  mct_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // global registers
  assign wr_clksel = wr_en && (addr == A_CLKSEL);
  assign wr_run    = wr_en && (addr == A_RUN);
  assign wr_mode   = wr_en && (addr == A_MODE);

  always_comb begin
    clksel_d = wdata[CS_TOT-1:0];
    run_d    = wdata[NUM_TMR-1:0];
    mode_d   = wdata[NUM_TMR-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      clksel_q <= '0;
      run_q    <= '0;
      mode_q   <= '0;
    end else begin
      if (wr_clksel) clksel_q <= clksel_d;
      if (wr_run)    run_q    <= run_d;
      if (wr_mode)   mode_q   <= mode_d;
    end
  end

  // timer channels
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic               blk_wr;
    logic [NUM_CMP-1:0] wr_match;

    assign blk_wr = wr_en && (addr[7:4] == 4'(t + 1));

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_mw
      assign wr_match[k] = blk_wr && (addr[3:0] == 4'(k));
    end

    mct_channel #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .CAP_DLY(CAP_DLY)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .run        (run_q[t]),
      .wr_match   (wr_match),
      .wr_stat    (blk_wr && (addr[3:0] == OFS_STAT)),
      .wr_ier     (blk_wr && (addr[3:0] == OFS_IER)),
      .wr_reload  (blk_wr && (addr[3:0] == OFS_RELOAD)),
      .wr_cap     (blk_wr && (addr[3:0] == OFS_CAP)),
      .wdata      (wdata),
      .match_q    (match_all[t]),
      .stat_q     (stat_all[t]),
      .ier_q      (ier_all[t]),
      .periodic_q (per_all[t]),
      .cap_q      (cap_all[t]),
      .irq        (irq[t])
    );

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (ier_all[t] == '0) |-> !irq[t]);
  end

  // read mux
  always_comb begin
    rdata_c = '0;
    if (addr == A_CLKSEL)    rdata_c = CNT_W'(clksel_q);
    else if (addr == A_RUN)  rdata_c = CNT_W'(run_q);
    else if (addr == A_MODE) rdata_c = CNT_W'(mode_q);
    for (int t = 0; t < NUM_TMR; t++) begin
      if (addr[7:4] == 4'(t + 1)) begin
        for (int k = 0; k < NUM_CMP; k++) begin
          if (addr[3:0] == 4'(k)) rdata_c = match_all[t][k];
        end
        case (addr[3:0])
          OFS_STAT:   rdata_c = CNT_W'(stat_all[t]);
          OFS_IER:    rdata_c = CNT_W'(ier_all[t]);
          OFS_RELOAD: rdata_c = CNT_W'(per_all[t]);
          OFS_CAP:    rdata_c = cap_all[t];
          default:    ;
        endcase
      end
    end
  end

  assign rdata = rdata_c;

  // R9
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_mode |=> (mode_q == $past(wdata[NUM_TMR-1:0])));
  // R9
  clksel_store_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_clksel) |=> $stable(clksel_q));
endmodule

// File: tb/mc_match_timer_tb.sv
`timescale 1ns/1ps
module mc_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;   // 50 MHz

  mc_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // vector: {match0[15:0], periodic, wait[15:0], expected status bit 0}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {16'd4, 1'b0, 16'd4,  1'b0},
    {16'd4, 1'b0, 16'd5,  1'b1},
    {16'd0, 1'b0, 16'd0,  1'b0},
    {16'd0, 1'b0, 16'd1,  1'b1},
    {16'd9, 1'b1, 16'd9,  1'b0},
    {16'd9, 1'b1, 16'd10, 1'b1}
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h01, v); check("R1 run word", v, 32'h0);
    rd(8'h13, v); check("R1 status", v, 32'h0);
    rd(8'h16, v); check("R1 capture", v, 32'h0);
    rd(8'h10, v); check("R1 match0", v, 32'h0);
    check("R1 irq", {29'b0, irq}, 32'h0);

    // table of match-timing vectors on timer 0
    for (int i = 0; i < NV; i++) begin
      wr(8'h01, 32'h0);
      wr(8'h13, 32'h7);
      wr(8'h10, {16'h0, VEC[i][33:18]});
      wr(8'h15, {31'h0, VEC[i][17]});
      wr(8'h14, 32'h1);
      wr(8'h01, 32'h1);
      repeat (int'(VEC[i][16:1])) @(negedge clk);
      rd(8'h13, v);
      check("R4 match timing vector", {31'b0, v[0]}, {31'b0, VEC[i][0]});
    end

    // R6 masking and R5 per-bit clears
    wr(8'h01, 32'h0);
    wr(8'h13, 32'h7);
    wr(8'h10, 32'd3);
    wr(8'h15, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h01, 32'h1);
    repeat (6) @(negedge clk);
    rd(8'h13, v); check("R4 all comparators hit", v, 32'h7);
    check("R6 masked irq", {31'b0, irq[0]}, 32'h0);
    wr(8'h14, 32'h1);
    check("R6 enabled irq", {31'b0, irq[0]}, 32'h1);
    wr(8'h13, 32'h0);
    rd(8'h13, v); check("R5 zero write keeps", v, 32'h7);
    wr(8'h13, 32'h2);
    rd(8'h13, v); check("R5 clear bit1 only", v, 32'h5);
    wr(8'h13, 32'h5);
    rd(8'h13, v); check("R5 cleared", v, 32'h0);
    check("R6 irq drops", {31'b0, irq[0]}, 32'h0);

    // R8 capture latency, free running
    wr(8'h01, 32'h0);
    wr(8'h01, 32'h1);
    repeat (10) @(negedge clk);
    wr(8'h16, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h16, v); check("R8 old value before delay", v, 32'h0);
    @(negedge clk);
    rd(8'h16, v); check("R8 snapshot", v, 32'd10);

    // R7 periodic wrap
    wr(8'h01, 32'h0);
    wr(8'h10, 32'd4);
    wr(8'h15, 32'h9);
    rd(8'h15, v); check("R7 reload readback", v, 32'h1);
    wr(8'h01, 32'h1);
    repeat (13) @(negedge clk);
    wr(8'h16, 32'h0);
    repeat (4) @(negedge clk);
    rd(8'h16, v); check("R7 periodic count", v, 32'd3);

    // R2 run 0x2 runs only timer 1
    wr(8'h01, 32'h2);
    repeat (6) @(negedge clk);
    wr(8'h16, 32'h0);
    wr(8'h26, 32'h0);
    repeat (4) @(negedge clk);
    rd(8'h16, v); check("R2 timer0 idle", v, 32'h0);
    rd(8'h26, v); check("R2 timer1 counts", v, 32'd7);

    // R3 stop clears, restart from zero
    wr(8'h01, 32'h0);
    wr(8'h01, 32'h2);
    repeat (2) @(negedge clk);
    wr(8'h26, 32'h0);
    repeat (4) @(negedge clk);
    rd(8'h26, v); check("R3 restart from zero", v, 32'd2);
    wr(8'h01, 32'h0);
    repeat (2) @(negedge clk);
    wr(8'h26, 32'h0);
    repeat (4) @(negedge clk);
    rd(8'h26, v); check("R3 stopped holds zero", v, 32'h0);

    // R4 comparator 2 on timer 1 with irq
    wr(8'h22, 32'd7);
    wr(8'h23, 32'h7);
    wr(8'h24, 32'h4);
    wr(8'h01, 32'h2);
    repeat (7) @(negedge clk);
    rd(8'h23, v); check("R4 cmp2 one early", {31'b0, v[2]}, 32'h0);
    check("R6 irq1 not yet", {31'b0, irq[1]}, 32'h0);
    @(negedge clk);
    rd(8'h23, v); check("R4 cmp2 set", {31'b0, v[2]}, 32'h1);
    check("R6 irq1 raised", {31'b0, irq[1]}, 32'h1);

    // R9 storage words
    wr(8'h00, 32'h2D);
    rd(8'h00, v); check("R9 clock select", v, 32'h2D);
    wr(8'h02, 32'h5);
    rd(8'h02, v); check("R9 mode", v, 32'h5);

    finish_run();
  end
endmodule